// File: doc/BRIEF.md
# Timer Mode Control Register with Write Lock

This block is the mode-control register of a timer/PWM peripheral. Its mode bits are a feature-set enable (extended registers usable), a capture-test enable, a synchronization-mode select, and a strobe that loads every timer output channel from its initial-value register. It also holds a write lock that guards the feature-set and capture-test bits. The timer datapath that these outputs steer is outside this block.

Software uses two addresses on a plain register bus. The mode word is at `MODE_ADDR`. The status word is at `STAT_ADDR`, and it shows the lock-enabled flag. The lock is a single state with two views: status bit 6 shows "locked", and mode bit 4 shows "unlocked".

To lift the lock, software reads the status word and sees the locked flag set. Its next bus access must then be a write of 1 to mode bit 4. Idle cycles may sit between the read and the write. Writing 1 to status bit 6 locks the register again at once.

Mode word layout:
- bit 0: feature-set enable (locked)
- bit 1: capture-test enable (locked)
- bit 2: sync select. 0 means either software or hardware triggers may drive any update. 1 means software triggers drive only the period and compare updates, and hardware triggers drive only the mask and counter updates.
- bit 3: initialize strobe
- bit 4: unlocked view

Top module: `tmr_mode_ctl`

## Requirements
- R1: After reset the register is locked (`prot_on_o`=1), the feature-set, capture-test and sync-select outputs are 0, `init_pulse_o` is 0, the mode word reads 0x00, and the status word reads 0x40.
- R2: A write to the status word with bit 6 set locks the register from the next cycle on. A write with bit 6 clear leaves the lock state unchanged.
- R3: If a status read returns bit 6 = 1 and the next bus access is a mode write with bit 4 = 1, the register is unlocked from the next cycle on. Idle cycles between the read and the write do not break the sequence.
- R4: A mode write with bit 4 = 0 never changes the lock state. A mode write with bit 4 = 1 and no armed read leaves the register locked.
- R5: Mode bits 0 (feature-set enable) and 1 (capture-test enable) take the written value only if the register was unlocked before that write. Otherwise they keep their stored value.
- R6: A mode write with bit 3 = 1 drives `init_pulse_o` high for exactly the cycle after the write. Bit 3 always reads back as 0, and a write with bit 3 = 0 gives no pulse.
- R7: Any bus read or write other than the armed mode write cancels an armed read. The one exception is a status read that again returns the locked flag, which re-arms.
- R8: Mode bit 2 (sync select) takes the written value on every mode write, locked or not.
- R9: Read data is combinational. Mode bit 4 reads as the inverse of status bit 6. Unused bits, other addresses, and cycles with `bus_rd` low all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, same cycle |
| feat_en_o | output | 1 | Extended register set enabled |
| cap_test_o | output | 1 | Capture test mode |
| sync_sel_o | output | 1 | Trigger routing select |
| init_pulse_o | output | 1 | One-cycle output-channel initialize |
| prot_on_o | output | 1 | Write lock active |

## Verification
Random sequences are weighted toward status reads followed by mode writes, so valid unlocks occur often. The same sequences are broken up by idle cycles and stray accesses. This separates a correct arm/cancel rule from one that ignores interleaving or cancels on idle cycles.

Directed cases cover four situations:
- an unlock write with no prior read
- a zero written to the unlocked view
- a write that unlocks and changes locked bits in the same cycle, which must not apply them
- back-to-back initialize strobes

Every access is compared against a bench model of the lock state, the stored fields and the read data.

// File: rtl/tmr_mode_pkg.sv
package tmr_mode_pkg;
  localparam int unsigned FEAT_BIT = 0;
  localparam int unsigned CAPT_BIT = 1;
  localparam int unsigned SYNC_BIT = 2;
  localparam int unsigned INIT_BIT = 3;
  localparam int unsigned UNLK_BIT = 4;
  localparam int unsigned LOCK_BIT = 6;

  typedef struct packed {
    logic feat_en;
    logic cap_test;
    logic sync_sel;
  } mode_fields_t;
endpackage

// File: rtl/tmr_wp_lock.sv
module tmr_wp_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd_hit,
  input  logic stat_wr_lock,
  input  logic mode_wr_hit,
  input  logic unlock_req,
  input  logic any_access,
  output logic prot_on,
  output logic armed
);
  logic prot_d;
  logic armed_d;

  always_comb begin
    prot_d = prot_on;
    if (stat_wr_lock)
      prot_d = 1'b1;
    else if (mode_wr_hit && unlock_req && armed && prot_on)
      prot_d = 1'b0;
  end

  always_comb begin
    armed_d = armed;
    if (stat_rd_hit && prot_on)
      armed_d = 1'b1;
    else if (any_access)
      armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_on <= 1'b1;
      armed   <= 1'b0;
    end else begin
      prot_on <= prot_d;
      armed   <= armed_d;
    end
  end

  AST_LOCK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_lock |=> prot_on); // R2
  AST_UNLOCK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(armed) && $past(mode_wr_hit)); // R3
  AST_ZERO_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_hit && !unlock_req && prot_on) |=> prot_on); // R4
  AST_ARM_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (any_access && !stat_rd_hit) |=> !armed); // R7
endmodule

// File: rtl/tmr_mode_fields.sv
module tmr_mode_fields
  import tmr_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              prot_on,
  output mode_fields_t      fields,
  output logic              init_pulse
);
  mode_fields_t fields_d;

  always_comb begin
    fields_d = fields;
    if (mode_wr_hit) begin
      fields_d.sync_sel = wdata[SYNC_BIT];
      if (!prot_on) begin
        fields_d.feat_en  = wdata[FEAT_BIT];
        fields_d.cap_test = wdata[CAPT_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields     <= '0;
      init_pulse <= 1'b0;
    end else begin
      fields     <= fields_d;
      init_pulse <= mode_wr_hit && wdata[INIT_BIT];
    end
  end

  AST_LOCKED_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    prot_on |=> $stable(fields.feat_en) && $stable(fields.cap_test)); // R5
  AST_INIT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |-> $past(mode_wr_hit) && $past(wdata[INIT_BIT])); // R6
  AST_SYNC_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_hit |=> fields.sync_sel == $past(wdata[SYNC_BIT])); // R8
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rd,
  input  logic              mode_sel,
  input  logic              stat_sel,
  input  mode_fields_t      fields,
  input  logic              prot_on,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd && mode_sel) begin
      rdata[FEAT_BIT] = fields.feat_en;
      rdata[CAPT_BIT] = fields.cap_test;
      rdata[SYNC_BIT] = fields.sync_sel;
      rdata[UNLK_BIT] = ~prot_on;
    end else if (rd && stat_sel) begin
      rdata[LOCK_BIT] = prot_on;
    end
  end

  always_comb begin
    if (rd && mode_sel)
      AST_DUAL_VIEW: assert (rdata[INIT_BIT] == 1'b0); // R6
  end
endmodule

// File: rtl/tmr_mode_ctl.sv
module tmr_mode_ctl
  import tmr_mode_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 4'h9,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              feat_en_o,
  output logic              cap_test_o,
  output logic              sync_sel_o,
  output logic              init_pulse_o,
  output logic              prot_on_o
);
  logic         mode_sel, stat_sel;
  logic         prot_on, armed;
  mode_fields_t fields;
  logic         unused_armed;

  assign mode_sel = (bus_addr == MODE_ADDR);
  assign stat_sel = (bus_addr == STAT_ADDR);

  tmr_wp_lock u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat_rd_hit  (bus_rd && stat_sel),
    .stat_wr_lock (bus_wr && stat_sel && bus_wdata[LOCK_BIT]),
    .mode_wr_hit  (bus_wr && mode_sel),
    .unlock_req   (bus_wdata[UNLK_BIT]),
    .any_access   (bus_rd || bus_wr),
    .prot_on      (prot_on),
    .armed        (armed)
  );

  tmr_mode_fields #(.DATA_W(DATA_W)) u_fields (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr_hit (bus_wr && mode_sel),
    .wdata       (bus_wdata),
    .prot_on     (prot_on),
    .fields      (fields),
    .init_pulse  (init_pulse_o)
  );

  tmr_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .rd       (bus_rd),
    .mode_sel (mode_sel),
    .stat_sel (stat_sel),
    .fields   (fields),
    .prot_on  (prot_on),
    .rdata    (bus_rdata)
  );

  assign unused_armed = armed;
  assign feat_en_o  = fields.feat_en;
  assign cap_test_o = fields.cap_test;
  assign sync_sel_o = fields.sync_sel;
  assign prot_on_o  = prot_on;

  AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> prot_on_o); // R1
endmodule

// File: tb/tmr_mode_ctl_tb.sv
module tmr_mode_ctl_tb;
  localparam logic [3:0] MA = 4'h9;
  localparam logic [3:0] SA = 4'h1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       feat_en_o, cap_test_o, sync_sel_o, init_pulse_o, prot_on_o;

  int n_chk = 0, n_bad = 0;
  logic m_prot = 1'b1, m_arm = 1'b0, m_feat = 1'b0, m_cap = 1'b0, m_sync = 1'b0;

  always #2.5 clk = ~clk;

  tmr_mode_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .feat_en_o(feat_en_o), .cap_test_o(cap_test_o), .sync_sel_o(sync_sel_o),
    .init_pulse_o(init_pulse_o), .prot_on_o(prot_on_o)
  );

  function automatic logic [7:0] exp_rd(input logic rd, input logic [3:0] a);
    if (!rd) return 8'h00;
    if (a == MA) return {3'b000, ~m_prot, 1'b0, m_sync, m_cap, m_feat};
    if (a == SA) return {1'b0, m_prot, 6'b0};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one bus access; called and returning at a negative edge
  task automatic op(input logic rd, input logic wr, input logic [3:0] a, input logic [7:0] d);
    logic exp_pulse;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    chk("R9 rdata", bus_rdata, exp_rd(rd, a));
    exp_pulse = wr && (a == MA) && d[3];
    if (wr && a == MA) begin
      m_sync = d[2];
      if (!m_prot) begin m_feat = d[0]; m_cap = d[1]; end
      if (d[4] && m_arm && m_prot) m_prot = 1'b0;
    end
    if (wr && a == SA && d[6]) m_prot = 1'b1;
    if (rd && a == SA && exp_rd(1'b1, SA) != 0) m_arm = 1'b1;
    else if (rd || wr) m_arm = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R2/R3/R4/R7 prot_on", {7'b0, prot_on_o}, {7'b0, m_prot});
    chk("R5 locked fields", {6'b0, cap_test_o, feat_en_o}, {6'b0, m_cap, m_feat});
    chk("R8 sync_sel", {7'b0, sync_sel_o}, {7'b0, m_sync});
    chk("R6 init pulse", {7'b0, init_pulse_o}, {7'b0, exp_pulse});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 4'h0, 8'h00);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 prot_on", {7'b0, prot_on_o}, 8'h01);
    chk("R1 fields", {5'b0, sync_sel_o, cap_test_o, feat_en_o}, 8'h00);
    chk("R1 pulse", {7'b0, init_pulse_o}, 8'h00);
    bus_rd = 1'b1; bus_addr = MA; #1; chk("R1 mode read", bus_rdata, 8'h00);
    bus_addr = SA; #1; chk("R1 status read", bus_rdata, 8'h40);
    bus_rd = 1'b0; @(negedge clk);
    // R4 unlock with no armed read
    op(1'b0, 1'b1, MA, 8'h13);
    chk("R4 no arm stays locked", {7'b0, prot_on_o}, 8'h01);
    chk("R5 locked write ignored", {6'b0, cap_test_o, feat_en_o}, 8'h00);
    // R4 zero to unlock bit after arm
    op(1'b1, 1'b0, SA, 8'h00);
    op(1'b0, 1'b1, MA, 8'h03);
    chk("R4 zero write keeps lock", {7'b0, prot_on_o}, 8'h01);
    // R3 unlock with idle gap; same write's fields not applied (R5)
    op(1'b1, 1'b0, SA, 8'h00);
    idle(3);
    op(1'b0, 1'b1, MA, 8'h17);
    chk("R3 unlocked", {7'b0, prot_on_o}, 8'h00);
    chk("R5 unlock write fields held", {6'b0, cap_test_o, feat_en_o}, 8'h00);
    op(1'b0, 1'b1, MA, 8'h03);
    chk("R5 unlocked write applies", {6'b0, cap_test_o, feat_en_o}, 8'h03);
    // R6 back-to-back strobes
    op(1'b0, 1'b1, MA, 8'h08);
    op(1'b0, 1'b1, MA, 8'h08);
    idle(1);
    // R2 zero then one to lock bit
    op(1'b0, 1'b1, SA, 8'hBF);
    chk("R2 zero no effect", {7'b0, prot_on_o}, 8'h00);
    op(1'b0, 1'b1, SA, 8'h40);
    chk("R2 relock", {7'b0, prot_on_o}, 8'h01);
    // R7 intervening access cancels arm
    op(1'b1, 1'b0, SA, 8'h00);
    op(1'b1, 1'b0, MA, 8'h00);
    op(1'b0, 1'b1, MA, 8'h10);
    chk("R7 cancelled arm", {7'b0, prot_on_o}, 8'h01);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      int k;
      k = $urandom_range(0, 9);
      a = (k < 4) ? SA : (k < 8) ? MA : 4'($urandom_range(0, 15));
      case ($urandom_range(0, 5))
        0, 1:    op(1'b1, 1'b0, a, 8'h00);
        2, 3:    op(1'b0, 1'b1, a, 8'($urandom));
        4:       op(1'b0, 1'b1, MA, 8'($urandom) | 8'h10);
        default: idle($urandom_range(1, 2));
      endcase
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule